// File: doc/BRIEF.md
# USB Host Port Resume Sequencer

This block is the per-port resume controller of a USB 2.0 host. It owns the read-back bit through which a port is pushed from suspend back into traffic. Software can start a resume by writing a one to that bit while the port is suspended. A device can also start one on its own: while the port sits in suspend, a J-to-K transition on the line sets the bit in hardware and raises a one-cycle port-change pulse toward the status register.

Once started, the hardware runs the resume by itself and software never ends it. The sequencer drives full-speed K for a programmable number of clock cycles, sized for 20 ms. It then drives the low-speed end-of-resume pattern, which is SE0 followed by J idle. After that it clears the bit and signals that the port is idle again.

Writes of zero to the bit have no effect. Losing port power stops everything at once. Software should keep the controller running through the resume, so that the first frame start reaches the device within 3 ms of the end of signaling.

Top module: `usb_port_resume_seq`

## Requirements
- R1: During and right after a synchronous reset (rst high), resume_bit, drive_k, drive_se0, port_change and idle_pulse are all 0.
- R2: With port power on and the port suspended, a write strobe (resume_wr=1) carrying resume_wdata=1 makes drive_k and resume_bit read 1 from the next clock cycle on, and port_change stays 0.
- R3: Line codes are J=2'b01, K=2'b10 and SE0=2'b00. While the port is suspended, the line is sampled as J and the next sample is K, port_change is 1 for exactly one cycle, and drive_k follows in the next cycle, with no write needed.
- R4: drive_k stays 1 for exactly RESUME_CYCLES consecutive cycles.
- R5: After the K phase, drive_se0 is 1 for exactly EOP_CYCLES cycles. Then both drives are 0 while resume_bit stays 1 for IDLE_CYCLES cycles. In the next cycle resume_bit reads 0 and idle_pulse is 1 for one cycle.
- R6: A write of resume_wdata=0 during a resume does not clear resume_bit and does not change the phase lengths.
- R7: A write of 1 while the port is not suspended is ignored: resume_bit and drive_k stay 0.
- R8: When port_power is 0, resume_bit, drive_k and drive_se0 read 0 in that same cycle. Any resume in progress is abandoned, and it does not restart when power returns.
- R9: A K sample that does not directly follow a J sample, or a J-to-K transition while the port is not suspended, produces neither port_change nor drive_k.
- R10: Once a resume has started, changes of port_suspended do not alter its phases or durations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_power | input | 1 | Port power bit |
| port_suspended | input | 1 | Port is in the suspend state |
| line_state | input | 2 | Line state from the PHY (J=01, K=10, SE0=00) |
| resume_wr | input | 1 | Write strobe for the resume bit |
| resume_wdata | input | 1 | Value written to the resume bit |
| drive_k | output | 1 | Drive full-speed K on the port |
| drive_se0 | output | 1 | Drive SE0 for the end-of-resume pattern |
| resume_bit | output | 1 | Readable resume bit |
| port_change | output | 1 | One-cycle port-change-detect pulse for a detected wakeup |
| idle_pulse | output | 1 | One-cycle flag that the port has returned to idle |

## Verification
A wrong phase register or a wrong timer value shows up at the ports as a K, SE0 or idle run whose length is off by whole cycles. It also shows up as a resume_bit that falls without the idle pulse. Either is visible at most RESUME_CYCLES+EOP_CYCLES+IDLE_CYCLES cycles after the trigger. A broken wake detector shows up one cycle after the K sample, as a missing, doubled or spurious port_change pulse. A state left over after a power loss shows up as K driven once power returns.

// File: rtl/usb_resume_pkg.sv
package usb_resume_pkg;

    localparam logic [1:0] LINE_SE0 = 2'b00;
    localparam logic [1:0] LINE_J   = 2'b01;
    localparam logic [1:0] LINE_K   = 2'b10;

    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,
        PH_RUN   = 3'd1,
        PH_SUSP  = 3'd2,
        PH_KDRV  = 3'd3,
        PH_EOP   = 3'd4,
        PH_JIDLE = 3'd5
    } port_phase_t;

    typedef struct packed {
        logic kstate;
        logic se0;
        logic bit_set;
    } port_drive_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic in_resume(input port_phase_t ph);
        return (ph == PH_KDRV) || (ph == PH_EOP) || (ph == PH_JIDLE);
    endfunction

endpackage

// File: rtl/usb_line_watch.sv
module usb_line_watch
    import usb_resume_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_state,
    output logic       jk_edge
);
    logic [1:0] cur_q;
    logic [1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= LINE_SE0;
            prev_q <= LINE_SE0;
        end else begin
            cur_q  <= line_state;
            prev_q <= cur_q;
        end
    end

    assign jk_edge = (prev_q == LINE_J) && (cur_q == LINE_K);

endmodule

// File: rtl/usb_phase_timer.sv
module usb_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt != {TW{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == limit - 1'b1);

endmodule

// File: rtl/usb_port_resume_seq.sv
module usb_port_resume_seq
    import usb_resume_pkg::*;
#(
    parameter int RESUME_CYCLES = 1200000,
    parameter int EOP_CYCLES    = 80,
    parameter int IDLE_CYCLES   = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       port_power,
    input  logic       port_suspended,
    input  logic [1:0] line_state,
    input  logic       resume_wr,
    input  logic       resume_wdata,
    output logic       drive_k,
    output logic       drive_se0,
    output logic       resume_bit,
    output logic       port_change,
    output logic       idle_pulse
);
    localparam int MAXC = max3(RESUME_CYCLES, EOP_CYCLES, IDLE_CYCLES);
    localparam int TW   = $clog2(MAXC + 1) + 1;

    port_phase_t   phase, phase_nxt;
    port_drive_t   drv;
    logic          jk_edge;
    logic          expired;
    logic          restart;
    logic          sw_start;
    logic [TW-1:0] limit;
    logic          idle_q;

    usb_line_watch u_watch (
        .clk        (clk),
        .rst        (rst),
        .line_state (line_state),
        .jk_edge    (jk_edge)
    );

    always_comb begin
        unique case (phase)
            PH_KDRV: limit = TW'(RESUME_CYCLES);
            PH_EOP:  limit = TW'(EOP_CYCLES);
            default: limit = TW'(IDLE_CYCLES);
        endcase
    end

    usb_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .limit   (limit),
        .expired (expired)
    );

    assign sw_start = resume_wr && resume_wdata;

    always_comb begin
        phase_nxt = phase;
        if (!port_power) begin
            phase_nxt = PH_OFF;
        end else begin
            unique case (phase)
                PH_OFF:   phase_nxt = PH_RUN;
                PH_RUN:   if (port_suspended) phase_nxt = PH_SUSP;
                PH_SUSP: begin
                    if (jk_edge || sw_start) phase_nxt = PH_KDRV;
                    else if (!port_suspended) phase_nxt = PH_RUN;
                end
                PH_KDRV:  if (expired) phase_nxt = PH_EOP;
                PH_EOP:   if (expired) phase_nxt = PH_JIDLE;
                PH_JIDLE: if (expired) phase_nxt = PH_RUN;
                default:  phase_nxt = PH_OFF;
            endcase
        end
    end

    assign restart = (phase_nxt != phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_OFF;
            idle_q <= 1'b0;
        end else begin
            phase  <= phase_nxt;
            idle_q <= port_power && (phase == PH_JIDLE) && expired;
        end
    end

    always_comb begin
        drv.kstate  = port_power && (phase == PH_KDRV);
        drv.se0     = port_power && (phase == PH_EOP);
        drv.bit_set = port_power && in_resume(phase);
    end

    assign drive_k     = drv.kstate;
    assign drive_se0   = drv.se0;
    assign resume_bit  = drv.bit_set;
    assign port_change = port_power && (phase == PH_SUSP) && jk_edge;
    assign idle_pulse  = idle_q;

    AST_K_FROM_SUSPEND: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_k) |-> $past(phase) == PH_SUSP); // R2
    AST_PCD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        port_change |=> !port_change); // R3
    AST_K_THEN_EOP: assert property (@(posedge clk) disable iff (rst)
        $fell(drive_k) && port_power |-> drive_se0); // R5
    AST_CLEAR_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(resume_bit) && port_power |-> idle_pulse); // R5
    AST_WR0_IGNORED: assert property (@(posedge clk) disable iff (rst)
        resume_bit && resume_wr && !resume_wdata && port_power
        |=> resume_bit || idle_pulse || !port_power); // R6
    AST_NO_START_UNSUSP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN) |=> !drive_k); // R7

endmodule

// File: tb/sim_usb_port_resume_seq.sv
module sim_usb_port_resume_seq;
    localparam int RC = 12;
    localparam int EC = 3;
    localparam int IC = 2;

    logic clk = 1'b0;
    logic rst, pwr, susp, wr, wd;
    logic [1:0] line;
    logic dk, dse0, rbit, pcd, idl;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    usb_port_resume_seq #(.RESUME_CYCLES(RC), .EOP_CYCLES(EC), .IDLE_CYCLES(IC)) u0 (
        .clk(clk), .rst(rst), .port_power(pwr), .port_suspended(susp),
        .line_state(line), .resume_wr(wr), .resume_wdata(wd),
        .drive_k(dk), .drive_se0(dse0), .resume_bit(rbit),
        .port_change(pcd), .idle_pulse(idl));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go_suspend();
        pwr = 1; susp = 0; line = 2'b01; wr = 0; wd = 0;
        step(3);
        susp = 1;
        step(2);
    endtask

    task automatic run_resume(input bit remote, input bit wr0);
        int n;
        string tag;
        tag = remote ? "R3" : "R2";
        go_suspend();
        if (remote) begin
            line = 2'b10;
            step();
            chk(pcd == 1'b1 && dk == 1'b0, "R3 wake pulse", pcd, 1);
            step();
            chk(pcd == 1'b0, "R3 pulse single", pcd, 0);
        end else begin
            wr = 1; wd = 1;
            step();
            wr = 0;
            chk(pcd == 1'b0, "R2 no pcd", pcd, 0);
        end
        chk(dk == 1'b1 && rbit == 1'b1, tag, dk, 1);
        susp = 0;
        line = 2'b01;
        n = 0;
        while (dk && n < 100) begin
            if (pcd) chk(1'b0, "R2 pcd during K", 1, 0);
            if (wr0 && n == 2) begin wr = 1; wd = 0; end
            if (n == 3) begin wr = 0; susp = 1; end
            n++;
            step();
        end
        susp = 0;
        chk(n == RC, "R4 R10 K length", n, RC);
        n = 0;
        while (dse0 && rbit && n < 100) begin
            if (wr0) begin wr = 1; wd = 0; end
            n++;
            step();
        end
        wr = 0;
        chk(n == EC, "R5 R6 SE0 length", n, EC);
        n = 0;
        while (rbit && !dk && !dse0 && n < 100) begin n++; step(); end
        chk(n == IC, "R5 R6 idle length", n, IC);
        chk(rbit == 1'b0 && idl == 1'b1, "R5 bit clear with idle pulse", idl, 1);
        step();
        chk(idl == 1'b0 && rbit == 1'b0, "R5 idle pulse single", idl, 0);
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        rst = 1; pwr = 0; susp = 0; line = 2'b00; wr = 0; wd = 0;
        step(3);
        chk({rbit, dk, dse0, pcd, idl} == 5'b0, "R1 reset outputs", {rbit, dk, dse0, pcd, idl}, 0);
        rst = 0;
        step();
        chk({rbit, dk, dse0, pcd, idl} == 5'b0, "R1 after reset", {rbit, dk, dse0, pcd, idl}, 0);

        for (int m = 0; m < 4; m++) run_resume(m[0], m[1]);

        for (int off = 0; off < RC + EC + IC; off++) begin
            go_suspend();
            wr = 1; wd = 1;
            step();
            wr = 0;
            step(off);
            pwr = 0;
            #1;
            chk(!rbit && !dk && !dse0, "R8 power loss quiet", {rbit, dk, dse0}, 0);
            step(2);
            pwr = 1;
            bad = 0;
            for (int i = 0; i < 5; i++) begin
                step();
                if (rbit || dk || dse0) bad++;
            end
            chk(bad == 0, "R8 no restart after power", bad, 0);
        end

        pwr = 1; susp = 0; line = 2'b01;
        step(3);
        wr = 1; wd = 1;
        step();
        wr = 0;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            if (rbit || dk) bad++;
            step();
        end
        chk(bad == 0, "R7 write while active", bad, 0);

        go_suspend();
        line = 2'b00;
        step();
        line = 2'b10;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            step();
            if (pcd || dk) bad++;
        end
        chk(bad == 0, "R9 SE0 to K no wake", bad, 0);

        susp = 0; line = 2'b01;
        step(3);
        line = 2'b10;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            step();
            if (pcd || dk) bad++;
        end
        chk(bad == 0, "R9 J to K while active", bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule